// File: doc/BRIEF.md
# Debug Register Frame Sequencer

This block turns one register-access request into a serial frame of single-bit operations and hands them, one at a time, to a separate bit transceiver that owns the line timing. A request names a 7-bit debug register, says whether it is a write or a read, and carries 32 bits of write data. The sequencer walks through a fixed 41-slot frame. A start bit comes first, then the register address and a direction bit. Last come 32 data slots, which the host drives on a write. On a read the host still times those slots, but it releases the line and samples what the target returns.

A read completes with the returned word and a one-cycle valid pulse. Every frame, read or write, ends with a one-cycle done pulse. The sequencer is used by a debug host that chains frames. A typical chain writes a memory address to register 0x05, writes a command word to register 0x17, and then reads the result from register 0x04.

The control is a four-state machine. `SQ_IDLE` waits for a request and takes it on `req_valid_i && req_ready_o` (transition *accept*) into `SQ_ISSUE`. `SQ_ISSUE` raises the bit request for one cycle and always moves on (transition *issued*) to `SQ_WAIT`. `SQ_WAIT` holds until the transceiver reports completion. On `bit_done_i` it either returns to `SQ_ISSUE` for the next slot (transition *next slot*) or, after slot 40, goes to `SQ_FINISH` (transition *last slot*). `SQ_FINISH` lasts one cycle, gives the done pulse and returns to `SQ_IDLE` (transition *retire*).

Top module: `dbg_frame_seq`

## Requirements
- R1: The first bit request of every frame (slot 0) has `bit_val_o` = 1 and `bit_drive_o` = 1. It is raised in the cycle after the request is accepted.
- R2: Slots 1 to 7 carry the 7-bit register address, most significant bit first, with `bit_drive_o` = 1.
- R3: Slot 8 is the direction bit, host-driven: 1 for a write and 0 for a read.
- R4: On a write, slots 9 to 40 carry the 32 write-data bits, most significant bit first, all with `bit_drive_o` = 1.
- R5: On a read, slots 9 to 40 have `bit_drive_o` = 0. The `bit_rx_i` value returned with each `bit_done_i` is shifted in, with the first one ending as bit 31 of `rsp_rdata_o`.
- R6: A frame is exactly 41 bit requests, with no acknowledge or parity slot. `done_o` is a one-cycle pulse in the cycle after the `bit_done_i` of slot 40.
- R7: `bit_req_o` is a one-cycle pulse. No further bit request is raised until `bit_done_i` has been seen for the current one, which the transceiver may return at any cycle from the one after the request.
- R8: `rsp_valid_o` pulses together with `done_o` on a read frame only, one cycle after the last bit completes. It stays low for a write.
- R9: `req_ready_o` is high only while idle. A request presented while a frame is running is not taken and produces no frame.
- R10: After reset the block is idle, with `req_ready_o` = 1 and `bit_req_o`, `done_o` and `rsp_valid_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Frame request present |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_addr_i | input | 7 | Debug register address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Data for a write frame |
| done_o | output | 1 | One-cycle pulse at the end of every frame |
| rsp_valid_o | output | 1 | One-cycle pulse when read data is ready |
| rsp_rdata_o | output | 32 | Word collected during a read frame |
| bit_req_o | output | 1 | One-cycle request for one bit slot |
| bit_drive_o | output | 1 | 1 = host drives the slot, 0 = host releases and samples |
| bit_val_o | output | 1 | Value to send in a host-driven slot |
| bit_done_i | input | 1 | Transceiver finished the requested slot |
| bit_rx_i | input | 1 | Sampled line value, valid with `bit_done_i` |

## Verification
The test drives writes and reads through a transceiver model that answers each slot after one to four cycles, rotating through those latencies. This shows that the slot order does not depend on how long each bit takes. Write data of all zeros, all ones and mixed patterns show that each data slot carries the right bit in MSB-first order. Read words of all ones, all zeros and an asymmetric pattern show the bit order and the exact 32-bit capture window. An address of all ones against an address of 0x04 checks the address field. The read chain 0x05, 0x17, 0x04 exercises the direction turn-around from one frame to the next, and a request held high during a running frame must neither be taken nor create an extra frame.

// File: rtl/dbg_frame_pkg.sv
package dbg_frame_pkg;

    localparam int unsigned DBG_ADDR_W = 7;
    localparam int unsigned DBG_DATA_W = 32;

    // Register numbers used by a typical memory-read chain
    localparam logic [DBG_ADDR_W-1:0] REG_RD_DATA  = 7'h04;
    localparam logic [DBG_ADDR_W-1:0] REG_MEM_ADDR = 7'h05;
    localparam logic [DBG_ADDR_W-1:0] REG_COMMAND  = 7'h17;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ISSUE  = 2'd1,
        SQ_WAIT   = 2'd2,
        SQ_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dfs_slot_counter.sv
module dfs_slot_counter #(
    parameter int unsigned SLOTS = 41,
    localparam int unsigned CW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] slot,
    output logic          last
);
    localparam logic [CW-1:0] LAST_IDX = CW'(SLOTS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (clear) begin
            slot <= '0;
        end else if (step && (slot != LAST_IDX)) begin
            slot <= slot + 1'b1;
        end
    end

    assign last = (slot == LAST_IDX);

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST_IDX) else $error("slot beyond frame"); // R6

endmodule

// File: rtl/dfs_tx_shift.sv
module dfs_tx_shift #(
    parameter int unsigned W = 41
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign msb = sr_q[W-1];

endmodule

// File: rtl/dfs_rx_shift.sv
module dfs_rx_shift #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift) begin
            word <= {word[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/dbg_frame_seq.sv
module dbg_frame_seq
    import dbg_frame_pkg::*;
#(
    parameter int unsigned ADDR_W = DBG_ADDR_W,
    parameter int unsigned DATA_W = DBG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_write_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              done_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              bit_req_o,
    output logic              bit_drive_o,
    output logic              bit_val_o,
    input  logic              bit_done_i,
    input  logic              bit_rx_i
);
    localparam int unsigned HDR_LEN   = 1 + ADDR_W + 1;
    localparam int unsigned FRAME_LEN = HDR_LEN + DATA_W;
    localparam int unsigned CW        = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] HDR_IDX = CW'(HDR_LEN);

    seq_state_e state_q, state_d;
    logic       wr_q;
    logic       accept;
    logic       slot_done;
    logic       last_slot;
    logic       in_data;
    logic [CW-1:0] slot;
    logic [FRAME_LEN-1:0] frame_word;

    assign accept    = req_valid_i && req_ready_o;
    assign slot_done = (state_q == SQ_WAIT) && bit_done_i;
    assign in_data   = (slot >= HDR_IDX);
    assign frame_word = {1'b1, req_addr_i, req_write_i,
                         (req_write_i ? req_wdata_i : {DATA_W{1'b0}})};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
        end else if (accept) begin
            wr_q <= req_write_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (accept) state_d = SQ_ISSUE;
            SQ_ISSUE:  state_d = SQ_WAIT;
            SQ_WAIT:   if (bit_done_i) state_d = last_slot ? SQ_FINISH : SQ_ISSUE;
            SQ_FINISH: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready_o = 1'b0;
        bit_req_o   = 1'b0;
        done_o      = 1'b0;
        rsp_valid_o = 1'b0;
        unique case (state_q)
            SQ_IDLE:   req_ready_o = 1'b1;
            SQ_ISSUE:  bit_req_o   = 1'b1;
            SQ_WAIT:   ;
            SQ_FINISH: begin
                done_o      = 1'b1;
                rsp_valid_o = !wr_q;
            end
            default:   ;
        endcase
    end

    assign bit_drive_o = wr_q || !in_data;

    dfs_slot_counter #(.SLOTS(FRAME_LEN)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (slot_done),
        .slot  (slot),
        .last  (last_slot)
    );

    dfs_tx_shift #(.W(FRAME_LEN)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (frame_word),
        .shift    (slot_done),
        .msb      (bit_val_o)
    );

    dfs_rx_shift #(.W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (slot_done && !wr_q && in_data),
        .bit_in (bit_rx_i),
        .word   (rsp_rdata_o)
    );

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (bit_req_o && bit_val_o && bit_drive_o)) else $error("start bit"); // R1

    AST_SINGLE_BIT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req_o |=> !bit_req_o) else $error("bit request held"); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && req_ready_o)) else $error("done not a pulse"); // R6

    AST_RSP_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(bit_done_i)) else $error("rsp without last bit"); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready_o) else $error("ready while busy"); // R9

endmodule

// File: tb/test_dbg_frame_seq.sv
module test_dbg_frame_seq;
    import dbg_frame_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [6:0]  req_addr;
    logic [31:0] req_wdata;
    logic        done_o, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bit_req, bit_drive, bit_val, bit_done, bit_rx;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_frame_seq i_dbg_frame_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_write_i(req_write), .req_wdata_i(req_wdata),
        .done_o(done_o), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .bit_req_o(bit_req), .bit_drive_o(bit_drive), .bit_val_o(bit_val),
        .bit_done_i(bit_done), .bit_rx_i(bit_rx)
    );

    typedef struct packed {
        logic [6:0]  addr;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] tgt;
    } item_t;

    item_t exp_q[$];
    int n_checks = 0, n_fail = 0;
    int n_sent = 0, n_frames = 0, stray_req = 0;
    int slot_idx = 0, lat_sel = 0;
    logic [31:0] tgt_word = '0;
    logic cap_val [41];
    logic cap_drv [41];
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Transceiver model: answers each slot after 1..4 cycles
    initial begin
        int lat;
        bit_done = 1'b0;
        bit_rx   = 1'b0;
        forever begin
            @(negedge clk);
            bit_done = 1'b0;
            if (bit_req) begin
                if (slot_idx < 41) begin
                    cap_val[slot_idx] = bit_val;
                    cap_drv[slot_idx] = bit_drive;
                end
                lat = 1 + (lat_sel % 4);
                lat_sel++;
                repeat (lat) begin
                    @(negedge clk);
                    if (bit_req) stray_req++;
                end
                bit_rx   = (slot_idx >= 9 && slot_idx < 41) ? tgt_word[40 - slot_idx] : 1'b0;
                bit_done = 1'b1;
                slot_idx++;
            end
        end
    end

    // Monitor / scoreboard
    initial begin
        item_t e;
        logic [6:0]  got_addr;
        logic [31:0] got_data;
        bit hdr_drv, dat_drv, dat_rel;
        forever begin
            @(negedge clk);
            if (done_o) begin
                n_frames++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected frame", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(slot_idx == 41, "R6", "slot count", slot_idx, 41);
                    chk(cap_val[0] && cap_drv[0], "R1", "start bit", {cap_val[0], cap_drv[0]}, 2'b11);
                    hdr_drv = 1'b1;
                    for (int i = 0; i < 7; i++) begin
                        got_addr[6-i] = cap_val[1+i];
                        hdr_drv &= cap_drv[1+i];
                    end
                    hdr_drv &= cap_drv[8];
                    chk(got_addr == e.addr && hdr_drv, "R2", "address", got_addr, e.addr);
                    chk(cap_val[8] == e.wr, "R3", "direction", cap_val[8], e.wr);
                    dat_drv = 1'b1;
                    dat_rel = 1'b1;
                    for (int i = 0; i < 32; i++) begin
                        got_data[31-i] = cap_val[9+i];
                        dat_drv &= cap_drv[9+i];
                        dat_rel &= !cap_drv[9+i];
                    end
                    if (e.wr) begin
                        chk(got_data == e.wdata && dat_drv, "R4", "write data", got_data, e.wdata);
                        chk(!rsp_valid, "R8", "rsp_valid on write", rsp_valid, 0);
                    end else begin
                        chk(dat_rel, "R5", "read slots released", dat_rel, 1);
                        chk(rsp_rdata == e.tgt, "R5", "read data", rsp_rdata, e.tgt);
                        chk(rsp_valid, "R8", "rsp_valid on read", rsp_valid, 1);
                    end
                end
                slot_idx = 0;
                @(negedge clk);
                chk(!done_o && !rsp_valid, "R6", "done one cycle", {done_o, rsp_valid}, 0);
            end
        end
    end

    // Driver: pushes the expected item as it issues the request
    task automatic send(input logic [6:0] a, input logic wr, input logic [31:0] wd,
                        input logic [31:0] tgt);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        tgt_word  = tgt;
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        req_wdata = wd;
        it.addr = a; it.wr = wr; it.wdata = wd; it.tgt = tgt;
        exp_q.push_back(it);
        n_sent++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9", "ready after accept", req_ready, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        bit ready_seen;
        rst_n = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bit_req && !done_o && !rsp_valid, "R10", "reset state",
            {req_ready, bit_req, done_o, rsp_valid}, 4'b1000);

        send(REG_MEM_ADDR, 1'b1, 32'h2000_0000, 32'h0);
        send(REG_COMMAND,  1'b1, 32'h0023_07C0, 32'h0);
        send(REG_RD_DATA,  1'b0, 32'h0,         32'hA5C3_0F81);
        send(7'h7F,        1'b1, 32'hFFFF_FFFF, 32'h0);
        send(7'h00,        1'b0, 32'h0,         32'hFFFF_FFFF);

        // Request held during a running frame must be ignored (R9)
        send(REG_RD_DATA,  1'b0, 32'h0,         32'h0000_0000);
        req_valid = 1'b1; req_addr = 7'h55; req_write = 1'b1; req_wdata = 32'h1234_5678;
        ready_seen = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (req_ready) ready_seen = 1'b1;
        end
        req_valid = 1'b0;
        chk(!ready_seen, "R9", "ready while busy", ready_seen, 0);

        send(7'h2A,        1'b1, 32'h0000_0000, 32'h0);
        send(REG_RD_DATA,  1'b0, 32'h0,         32'h8000_0001);

        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(n_frames == n_sent, "R9", "frame count", n_frames, n_sent);
        chk(stray_req == 0, "R7", "request while slot pending", stray_req, 0);
        summary();
    end

endmodule